// File: doc/BRIEF.md
# Random Number Generator Controller

This block is the register-mapped control front end of a random number peripheral. Software talks to it over a 32-bit APB-style bus: it writes a command to start a generation or a reseed, watches status or an interrupt line, and then reads up to eight 32-bit result words. The generator runs a fixed-length sequence per request. The length is 1024 cycles for a 256-bit result and half that for a 128-bit result. A programmable counter of 16-byte units triggers an automatic reseed once enough output has been produced.

The entropy source and conditioning are replaced by a 32-bit Galois LFSR that is loaded from a fixed base value on every reseed, so a bench can predict every word. After reset the block reseeds itself before it accepts any command. Interrupt flags are sticky and are cleared by writing ones. The interrupt line combines a global enable with per-flag enables.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset the block reseeds by itself. While it does so, STAT reads 0x8000_0000 (bit 31 reseeding, bit 9 seeded clear). After SEED_CYCLES (64) cycles STAT bit 9 is set and stays set.
- R2: Address 0xF0 reads the constant 0x0000_46BC. An address with no register reads zero.
- R3: A write to CTRL (0x00) with bits [1:0] = 1 starts a generation, = 2 starts a reseed, and 0 or 3 does nothing. STAT bit 30 reads 1 while a generation runs, and the block never generates and reseeds at the same time.
- R4: With MODE (0x08) bit 3 = 1, ISTAT (0x14) bit 0 sets exactly 1024 clock edges after the edge that accepts the generate write. Words 0 to 7 then read at 0x20 + 4*i.
- R5: With MODE bit 3 = 0, ISTAT bit 0 sets after 512 edges. Only words 0 to 3 are written, and words 4 to 7 read zero. The mode is sampled when the command is accepted.
- R6: Word i of a result is the (i+1)-th successor of the LFSR state, where next(s) = (s >> 1) ^ (s[0] ? 0x8020_0003 : 0). A 256-bit result consumes 8 states and a 128-bit result consumes 4. Reseed number k (k = 1 is the one after reset) loads 0x6A09_E667 ^ k.
- R7: All result words read zero until the first generation completes.
- R8: Writing ISTAT clears each flag whose written bit is 1 and leaves flags written with 0 unchanged. A flag set in the same cycle as the clear wins.
- R9: irq = IE[31] & ((IE[0] & ISTAT[0]) | (IE[1] & ISTAT[1])), where IE is at 0x10.
- R10: A generate or reseed command written while a generation or reseed runs is ignored. It changes neither the running operation nor the later results.
- R11: When AUTO (0x60) holds N ≠ 0, each 256-bit result counts 2 units and each 128-bit result counts 1 unit. When the total reaches N, a reseed starts on the edge that completes the generation (STAT bit 31) and the total restarts at zero. When AUTO is 0, no reseed is triggered automatically.
- R12: The completion of any reseed (after reset, on command or automatic) sets ISTAT bits 1 and 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the properties that do not depend on the data:
- generation and reseed never overlap;
- a running operation is not cut short;
- the seeded bit is sticky;
- the flags set and clear as required;
- the generation latency matches the latched mode;
- the upper words are zeroed in 128-bit mode;
- the result words stay zero before the first generation.

Only the bench scenarios can show that the result words follow the LFSR and seed model across modes, pokes while busy, and manual and automatic reseeds. The same holds for the exact cycle at which the interrupt line rises and for the value of the unit total at which an automatic reseed starts.

// File: rtl/rng_pkg.sv
// Package: shared register offsets, command codes and sequencer states
// for the random number generator controller. Assumes a byte-addressed
// 8-bit register window with 32-bit aligned registers.
package rng_pkg;
    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_MODE  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_IE    = 8'h10;
    localparam logic [REG_AW-1:0] OFF_ISTAT = 8'h14;
    localparam logic [REG_AW-1:0] OFF_WORD0 = 8'h20;
    localparam logic [REG_AW-1:0] OFF_AUTO  = 8'h60;
    localparam logic [REG_AW-1:0] OFF_VER   = 8'hF0;

    localparam logic [31:0] VERSION_CODE = 32'h0000_46BC;

    localparam logic [1:0] CMD_NONE = 2'd0;
    localparam logic [1:0] CMD_GEN  = 2'd1;
    localparam logic [1:0] CMD_SEED = 2'd2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_GEN  = 2'd1,
        SQ_SEED = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rng_sequencer.sv
// Module: rng_sequencer
// Runs one operation at a time: a generation of fixed length (full or
// half according to the latched width) or a reseed of SEED_CYCLES.
// Enters a reseed straight out of reset. Counts produced 16-byte units
// and chains an automatic reseed when the programmed limit is reached.
// Assumes cmd_valid is a single-cycle strobe. Commands that arrive while
// an operation runs are dropped.
module rng_sequencer #(
    parameter int unsigned GEN_CYCLES  = 1024,
    parameter int unsigned SEED_CYCLES = 64,
    parameter int unsigned UNIT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    input  logic              wide_req,
    input  logic [UNIT_W-1:0] auto_limit,
    output logic              gen_busy,
    output logic              seed_busy,
    output logic              seeded,
    output logic              gen_wide,
    output logic              gen_done,
    output logic              seed_done
);
    import rng_pkg::*;

    localparam int unsigned MAX_CYC = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC) + 1;
    localparam logic [CNT_W-1:0] GEN_LAST_FULL = CNT_W'(GEN_CYCLES - 1);
    localparam logic [CNT_W-1:0] GEN_LAST_HALF = CNT_W'(GEN_CYCLES / 2 - 1);
    localparam logic [CNT_W-1:0] SEED_LAST     = CNT_W'(SEED_CYCLES - 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wide_q;
    logic              seeded_q;
    logic [UNIT_W-1:0] units_q;
    logic [UNIT_W:0]   units_sum;
    logic              reseed_due;
    logic [CNT_W-1:0]  gen_last;

    // Last count of the running generation, chosen by the latched width.
    assign gen_last  = wide_q ? GEN_LAST_FULL : GEN_LAST_HALF;
    assign gen_done  = (state_q == SQ_GEN)  && (cnt_q == gen_last);
    assign seed_done = (state_q == SQ_SEED) && (cnt_q == SEED_LAST);

    // Unit total including the result that completes now.
    assign units_sum  = {1'b0, units_q} + (wide_q ? (UNIT_W+1)'(2) : (UNIT_W+1)'(1));
    assign reseed_due = (auto_limit != '0) && (units_sum >= {1'b0, auto_limit});

    // State, cycle counter, latched width, seeded flag and unit total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_SEED;
            cnt_q    <= '0;
            wide_q   <= 1'b0;
            seeded_q <= 1'b0;
            units_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid && (cmd_code == CMD_GEN)) begin
                        state_q <= SQ_GEN;
                        cnt_q   <= '0;
                        wide_q  <= wide_req;
                    end else if (cmd_valid && (cmd_code == CMD_SEED)) begin
                        state_q <= SQ_SEED;
                        cnt_q   <= '0;
                        units_q <= '0;
                    end
                end
                SQ_GEN: begin
                    if (gen_done) begin
                        cnt_q <= '0;
                        if (reseed_due) begin
                            state_q <= SQ_SEED;
                            units_q <= '0;
                        end else begin
                            state_q <= SQ_IDLE;
                            units_q <= (auto_limit == '0) ? '0 : units_sum[UNIT_W-1:0];
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_SEED: begin
                    if (seed_done) begin
                        state_q  <= SQ_IDLE;
                        cnt_q    <= '0;
                        seeded_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign gen_busy  = (state_q == SQ_GEN);
    assign seed_busy = (state_q == SQ_SEED);
    assign seeded    = seeded_q;
    assign gen_wide  = wide_q;
endmodule

// File: rtl/rng_lfsr_bank.sv
// Module: rng_lfsr_bank
// Deterministic stand-in for the entropy path. It holds one Galois LFSR
// state and unrolls NUM_WORDS successor states combinationally. Each
// reseed loads SEED_BASE xor the running reseed number. Each advance
// consumes all or half of the unrolled states.
// Assumes reseed and advance are never high in the same cycle.
module rng_lfsr_bank #(
    parameter int unsigned   NUM_WORDS = 8,
    parameter int unsigned   WORD_W    = 32,
    parameter logic [WORD_W-1:0] TAPS      = 32'h8020_0003,
    parameter logic [WORD_W-1:0] SEED_BASE = 32'h6A09_E667
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reseed,
    input  logic                              advance,
    input  logic                              wide,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);
    localparam int unsigned HALF = NUM_WORDS / 2;

    logic [WORD_W-1:0]                state_q;
    logic [WORD_W-1:0]                idx_q;
    logic [WORD_W-1:0]                idx_next;
    logic [NUM_WORDS:0][WORD_W-1:0]   chain;

    // One Galois step shifting toward bit 0.
    function automatic logic [WORD_W-1:0] step(input logic [WORD_W-1:0] s);
        step = (s >> 1) ^ (s[0] ? TAPS : '0);
    endfunction

    assign chain[0] = state_q;
    assign idx_next = idx_q + 1'b1;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_chain
        // Successor i+1 of the held state, exposed as output word i.
        assign chain[i+1] = step(chain[i]);
        assign words[i]   = chain[i+1];
    end

    // Holds the LFSR state and the reseed number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED_BASE;
            idx_q   <= '0;
        end else if (reseed) begin
            state_q <= SEED_BASE ^ idx_next;
            idx_q   <= idx_next;
        end else if (advance) begin
            state_q <= wide ? chain[NUM_WORDS] : chain[HALF];
        end
    end
endmodule

// File: rtl/rng_ctrl_top.sv
// Module: rng_ctrl_top
// Register front end of the random number generator. It decodes a simple
// APB-style bus (write on psel & penable & pwrite, combinational read
// data), holds the control, mode, enable, flag and auto-reseed registers,
// captures result words at the end of each generation, and drives irq.
// Assumes one access per two-phase transfer and 32-bit aligned addresses.
module rng_ctrl_top #(
    parameter int unsigned NUM_WORDS   = 8,
    parameter int unsigned GEN_CYCLES  = 1024,
    parameter int unsigned SEED_CYCLES = 64,
    parameter logic [31:0] LFSR_TAPS   = 32'h8020_0003,
    parameter logic [31:0] SEED_BASE   = 32'h6A09_E667
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [7:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq
);
    import rng_pkg::*;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF   = NUM_WORDS / 2;
    localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
    localparam logic [REG_AW-1:0] WIN_BYTES = REG_AW'(4 * NUM_WORDS);

    logic        wr_en;
    logic        cmd_valid;
    logic [1:0]  ctrl_q;
    logic        mode_wide_q;
    logic        ie_glb_q, ie_seed_q, ie_rdy_q;
    logic [1:0]  istat_q;
    logic [1:0]  istat_clr;
    logic [1:0]  istat_set;
    logic [31:0] auto_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] out_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] lfsr_words;

    logic gen_busy, seed_busy, seeded, gen_wide, gen_done, seed_done;

    logic [REG_AW-1:0] woff;
    logic              word_hit;

    assign wr_en     = psel && penable && pwrite;
    assign cmd_valid = wr_en && (paddr == OFF_CTRL);

    rng_sequencer #(
        .GEN_CYCLES (GEN_CYCLES),
        .SEED_CYCLES(SEED_CYCLES),
        .UNIT_W     (32)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (pwdata[1:0]),
        .wide_req  (mode_wide_q),
        .auto_limit(auto_q),
        .gen_busy  (gen_busy),
        .seed_busy (seed_busy),
        .seeded    (seeded),
        .gen_wide  (gen_wide),
        .gen_done  (gen_done),
        .seed_done (seed_done)
    );

    rng_lfsr_bank #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_W   (WORD_W),
        .TAPS     (LFSR_TAPS),
        .SEED_BASE(SEED_BASE)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (seed_done),
        .advance(gen_done),
        .wide   (gen_wide),
        .words  (lfsr_words)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= CMD_NONE;
            mode_wide_q <= 1'b0;
            ie_glb_q    <= 1'b0;
            ie_seed_q   <= 1'b0;
            ie_rdy_q    <= 1'b0;
            auto_q      <= '0;
        end else if (wr_en) begin
            case (paddr)
                OFF_CTRL: ctrl_q      <= pwdata[1:0];
                OFF_MODE: mode_wide_q <= pwdata[3];
                OFF_IE: begin
                    ie_glb_q  <= pwdata[31];
                    ie_seed_q <= pwdata[1];
                    ie_rdy_q  <= pwdata[0];
                end
                OFF_AUTO: auto_q <= pwdata;
                default: ;
            endcase
        end
    end

    // Flag set and write-one-to-clear sources; a set wins.
    assign istat_clr = (wr_en && (paddr == OFF_ISTAT)) ? pwdata[1:0] : 2'b00;
    assign istat_set = {seed_done, gen_done | seed_done};

    // Sticky interrupt flags.
    always_ff @(posedge clk) begin
        if (!rst_n) istat_q <= 2'b00;
        else        istat_q <= (istat_q & ~istat_clr) | istat_set;
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_out
        // Result word i, captured when a generation completes.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_q[i] <= '0;
            else if (gen_done) out_q[i] <= (gen_wide || (i < HALF)) ? lfsr_words[i] : '0;
        end
    end

    assign woff     = paddr - OFF_WORD0;
    assign word_hit = (paddr >= OFF_WORD0) && (woff < WIN_BYTES) && (paddr[1:0] == 2'b00);

    // Read data multiplexer.
    always_comb begin
        prdata = '0;
        case (paddr)
            OFF_CTRL:  prdata = {30'b0, ctrl_q};
            OFF_STAT:  prdata = {seed_busy, gen_busy, 20'b0, seeded, 9'b0};
            OFF_MODE:  prdata = {28'b0, mode_wide_q, 3'b0};
            OFF_IE:    prdata = {ie_glb_q, 29'b0, ie_seed_q, ie_rdy_q};
            OFF_ISTAT: prdata = {30'b0, istat_q};
            OFF_AUTO:  prdata = auto_q;
            OFF_VER:   prdata = VERSION_CODE;
            default:   if (word_hit) prdata = out_q[woff[IDX_W+1:2]];
        endcase
    end

    assign irq = ie_glb_q && ((ie_rdy_q && istat_q[0]) || (ie_seed_q && istat_q[1]));
endmodule

// File: rtl/rng_ctrl_checker.sv
// Module: rng_ctrl_checker
// Assertions for rng_ctrl_top, attached by bind. It observes the sequencer
// outputs, the flag register and the first and last result words.
// Assumes a synchronous active-low reset.
module rng_ctrl_checker #(
    parameter int unsigned GEN_CYCLES = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        gen_busy,
    input logic        seed_busy,
    input logic        seeded,
    input logic        gen_wide,
    input logic        gen_done,
    input logic        seed_done,
    input logic [1:0]  istat,
    input logic        clr0,
    input logic [31:0] w_first,
    input logic [31:0] w_last
);
    logic [31:0] lat_q;
    logic        seen_gen_q;

    // Cycles spent in the current generation, and whether one completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q      <= '0;
            seen_gen_q <= 1'b0;
        end else begin
            lat_q <= (gen_busy && !gen_done) ? lat_q + 1 : '0;
            if (gen_done) seen_gen_q <= 1'b1;
        end
    end

    a_r3_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_busy && seed_busy));
    a_r10_gen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_busy && !gen_done) |=> gen_busy);
    a_r10_seed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_busy && !seed_done) |=> seed_busy);
    a_r1_seeded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !gen_done && !seed_done) |=> !istat[0]);
    a_r12_flags: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done |=> (istat == 2'b11));
    a_r7_zero_before_gen: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_gen_q |-> (w_first == 32'h0));
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_done && !gen_wide) |=> (w_last == 32'h0));
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |-> (lat_q == (gen_wide ? GEN_CYCLES - 1 : GEN_CYCLES / 2 - 1)));
endmodule

bind rng_ctrl_top rng_ctrl_checker #(.GEN_CYCLES(GEN_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_busy (gen_busy),
    .seed_busy(seed_busy),
    .seeded   (seeded),
    .gen_wide (gen_wide),
    .gen_done (gen_done),
    .seed_done(seed_done),
    .istat    (istat_q),
    .clr0     (istat_clr[0]),
    .w_first  (out_q[0]),
    .w_last   (out_q[NUM_WORDS-1])
);

// File: tb/rng_ctrl_top_test.sv
module rng_ctrl_top_test;
    localparam int GEN = 1024;
    localparam logic [31:0] TAPS = 32'h8020_0003;
    localparam logic [31:0] BASE = 32'h6A09_E667;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_state;
    logic [31:0] m_idx;
    int          m_units;
    int          m_auto;
    bit          m_reseed;
    logic [31:0] exp_w [8];

    always #4 clk = ~clk;

    rng_ctrl_top uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1; #1; d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
    endfunction

    function automatic void model_seed();
        m_idx   = m_idx + 1;
        m_state = BASE ^ m_idx;
        m_units = 0;
    endfunction

    function automatic void model_gen(input bit wide);
        logic [31:0] s = m_state;
        for (int i = 0; i < 8; i++) begin
            if (wide || i < 4) begin s = nxt(s); exp_w[i] = s; end
            else exp_w[i] = 32'h0;
        end
        m_state  = s;
        m_reseed = 0;
        if (m_auto != 0) begin
            m_units += wide ? 2 : 1;
            if (m_units >= m_auto) begin m_units = 0; m_reseed = 1; end
        end
    endfunction

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            bus_rd(8'h04, d);
            if (d[31:30] == 2'b00) break;
        end
    endtask

    task automatic cmp_words(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            bus_rd(8'(8'h20 + 4 * i), d);
            chk(tag, d, exp_w[i]);
        end
    endtask

    // One generation with an exact latency check through irq; optional busy pokes.
    task automatic do_gen(input bit wide, input bit poke);
        logic [31:0] d;
        int lat;
        lat = wide ? GEN : GEN / 2;
        bus_wr(8'h08, {28'b0, wide, 3'b0});
        bus_wr(8'h14, 32'h3);
        bus_wr(8'h10, 32'h8000_0001);
        bus_wr(8'h00, 32'h1);
        if (poke) begin
            bus_wr(8'h00, 32'h1);   // R10 ignored while busy
            bus_wr(8'h00, 32'h2);   // R10 ignored while busy
            repeat (lat - 1 - 6) @(negedge clk);
        end else begin
            repeat (lat - 1) @(negedge clk);
        end
        chk(wide ? "R4 irq low one edge before ready" : "R5 irq low one edge before ready", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk(wide ? "R4 R9 irq at ready" : "R5 R9 irq at ready", {31'b0, irq}, 32'h1);
        model_gen(wide);
        if (m_reseed) begin
            bus_rd(8'h04, d);
            chk("R11 auto reseed started", d, 32'h8000_0200);
            wait_idle();
            bus_rd(8'h14, d);
            chk("R12 auto reseed flags", d, 32'h3);
            model_seed();
        end else begin
            bus_rd(8'h04, d);
            chk(poke ? "R10 no extra operation" : "R11 no reseed", d, 32'h0000_0200);
        end
        cmp_words(wide ? "R6 words 256" : "R5 R6 words 128");
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_state = BASE; m_idx = 0; m_units = 0; m_auto = 0; m_reseed = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_rd(8'h04, d);
        chk("R1 reseeding after reset", d, 32'h8000_0000);
        bus_rd(8'h20, d);
        chk("R7 word0 zero before gen", d, 32'h0);
        bus_rd(8'hF0, d);
        chk("R2 version", d, 32'h0000_46BC);
        bus_rd(8'h40, d);
        chk("R2 unmapped reads zero", d, 32'h0);
        chk("R9 irq low after reset", {31'b0, irq}, 32'h0);
        wait_idle();
        model_seed();
        bus_rd(8'h04, d);
        chk("R1 seeded", d, 32'h0000_0200);
        bus_rd(8'h14, d);
        chk("R12 reset reseed flags", d, 32'h3);

        // R8 / R9 flag and irq handling
        bus_wr(8'h10, 32'h8000_0002);
        chk("R9 irq seed enable", {31'b0, irq}, 32'h1);
        bus_wr(8'h14, 32'h1);
        bus_rd(8'h14, d);
        chk("R8 clear bit0 keep bit1", d, 32'h2);
        bus_wr(8'h10, 32'h0000_0002);
        chk("R9 global enable off", {31'b0, irq}, 32'h0);
        bus_wr(8'h14, 32'h2);
        bus_rd(8'h14, d);
        chk("R8 clear bit1", d, 32'h0);
        bus_wr(8'h00, 32'h3);
        bus_rd(8'h04, d);
        chk("R3 code 3 no operation", d, 32'h0000_0200);

        // R3 generate status
        bus_wr(8'h08, 32'h8);
        bus_wr(8'h00, 32'h1);
        bus_rd(8'h04, d);
        chk("R3 generating status", d, 32'h4000_0200);
        wait_idle();
        model_gen(1'b1);
        cmp_words("R6 first 256 result");

        do_gen(1'b1, 1'b0);
        do_gen(1'b0, 1'b0);
        do_gen(1'b1, 1'b1);

        // R3 / R12 manual reseed
        bus_wr(8'h14, 32'h3);
        bus_wr(8'h00, 32'h2);
        bus_rd(8'h04, d);
        chk("R3 reseed status", d, 32'h8000_0200);
        wait_idle();
        model_seed();
        bus_rd(8'h14, d);
        chk("R12 command reseed flags", d, 32'h3);
        do_gen(1'b0, 1'b0);

        // R11 automatic reseed
        bus_wr(8'h60, 32'd3);
        m_auto = 3; m_units = 0;
        do_gen(1'b1, 1'b0);
        do_gen(1'b1, 1'b0);
        do_gen(1'b0, 1'b0);

        // Random mix
        for (int it = 0; it < 14; it++) begin
            if (($urandom % 4) == 0) begin
                int a = $urandom % 5;
                bus_wr(8'h60, a);
                m_auto = a;
                if (a == 0) m_units = 0;
            end
            do_gen(1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule